// File: doc/BRIEF.md
# Output Short-Circuit Fault Supervisor

This block watches a current-limited output driver and decides when the driver must be switched off. The driver reports an over-current condition as a synchronized digital flag. A free-running one-microsecond tick enable is the timebase. A short counts as a fault only when the flag stays up for a full persistence window. The block then turns the driver off, raises a live fault bit and a sticky interrupt bit, and pulls the active-low interrupt request.

While a fault is active, the block does not keep the driver off for good. It runs a duty-cycled probe schedule. For most of each retry period the driver is off. For the last persistence-length part of the period it is switched back on, to test whether the short is still present. A clean probe window ends the fault. A probe window in which over-current is seen sends the driver back to off until the next slot.

The sticky bit and the interrupt request are cleared only by a status-read strobe. All pins are plain level or strobe control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `short_fault_supervisor`

## Requirements
- R1: After reset, drv_en is 1, fault_live is 0, fault_sticky is 0 and irq_n is 1.
- R2: A fault is registered only when ovc_flag is high on PERSIST_US consecutive us_tick cycles with no low cycle in between. Any cycle with ovc_flag low restarts the count.
- R3: In the cycle after a fault is registered, drv_en is 0, fault_live is 1, fault_sticky is 1 and irq_n is 0.
- R4: Time advances only on cycles with us_tick high. ovc_flag held high with no tick never registers a fault.
- R5: Each probe window starts PERIOD_US-PERSIST_US ticks after the driver was switched off, so windows start PERIOD_US ticks apart. drv_en stays 1 for PERSIST_US ticks in each window.
- R6: If ovc_flag is high in any cycle of a probe window, even for a single non-tick cycle, drv_en returns to 0 when the window ends. fault_live stays 1, and a failed probe does not set fault_sticky again.
- R7: If ovc_flag stays low for a whole probe window, then at its end fault_live clears and drv_en stays 1. Normal supervision resumes, and a later persistent short registers a new fault.
- R8: fault_sticky and irq_n change back only on a status_rd cycle with no fault registration in that same cycle. A read never changes fault_live or drv_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond; timing enable |
| ovc_flag | input | 1 | Synchronized over-current flag from the driver |
| status_rd | input | 1 | Status-read strobe; clears the sticky bit |
| drv_en | output | 1 | Driver enable |
| fault_live | output | 1 | Fault currently active |
| fault_sticky | output | 1 | Latched fault-interrupt bit |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench applies four kinds of over-current pattern, each of which separates one kind of fault from another:
- A flag held high with no ticks separates tick-based timing from cycle counting.
- A short broken by a single low cycle just before the limit separates a restart of the count from a pause of it.
- A probe window with the flag high throughout, and a window with a lone one-cycle pulse on a non-tick cycle, both show that any over-current seen in the window fails the probe.
- A fully clean window shows the recovery path and the re-arming of the persistence count.

Read strobes are placed during shutdown, after recovery, and in the same cycle as a new fault registration. This separates a set that wins over a clear from a clear that wins over a set.

// File: rtl/ocp_sup_pkg.sv
package ocp_sup_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_OFF   = 2'd1,
    ST_PROBE = 2'd2
  } sup_state_e;
endpackage

// File: rtl/ocp_persist.sv
// Persistence qualifier: counts consecutive ticks of over-current while armed.
module ocp_persist #(
  parameter int PERSIST_US = 440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ovc,
  input  logic armed,
  output logic fault_evt
);
  localparam int CW = $clog2(PERSIST_US + 1);
  localparam logic [CW-1:0] LAST = CW'(PERSIST_US - 1);

  logic [CW-1:0] run_cnt;

  assign fault_evt = armed && ovc && tick && (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!armed || !ovc || fault_evt) begin
      run_cnt <= '0;
    end else if (tick) begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

  // R2: the count never passes the limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < CW'(PERSIST_US));

  // R4: without a tick the count is frozen or restarted, never advanced
  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (run_cnt == $past(run_cnt)) || (run_cnt == '0));
endmodule

// File: rtl/ocp_retry_sched.sv
// Fault state machine with the duty-cycled probe schedule.
module ocp_retry_sched
  import ocp_sup_pkg::*;
#(
  parameter int PERSIST_US = 440,
  parameter int PERIOD_US  = 26000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ovc,
  input  logic       fault_evt,
  output sup_state_e state
);
  localparam int OFF_LEN = PERIOD_US - PERSIST_US;
  localparam int PW      = $clog2(PERIOD_US);
  localparam logic [PW-1:0] OFF_END  = PW'(OFF_LEN - 1);
  localparam logic [PW-1:0] SLOT_END = PW'(PERIOD_US - 1);

  logic [PW-1:0] phase;
  logic          seen;
  logic          probe_hit;
  logic          slot_done;

  assign probe_hit = seen | ovc;
  assign slot_done = tick && (phase == SLOT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_ARMED;
      phase <= '0;
      seen  <= 1'b0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (fault_evt) begin
            state <= ST_OFF;
            phase <= '0;
            seen  <= 1'b0;
          end
        end
        ST_OFF: begin
          if (tick) begin
            phase <= phase + PW'(1);
            if (phase == OFF_END) begin
              state <= ST_PROBE;
              seen  <= 1'b0;
            end
          end
        end
        ST_PROBE: begin
          if (slot_done) begin
            phase <= '0;
            seen  <= 1'b0;
            state <= probe_hit ? ST_OFF : ST_ARMED;
          end else begin
            seen <= probe_hit;
            if (tick) phase <= phase + PW'(1);
          end
        end
        default: begin
          state <= ST_ARMED;
          phase <= '0;
          seen  <= 1'b0;
        end
      endcase
    end
  end

  // R3: a registered fault shuts the driver off at the next edge
  p_evt_shutdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) && fault_evt |=> state == ST_OFF);

  // R6: a probe with over-current returns to off
  p_probe_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROBE) && slot_done && probe_hit |=> state == ST_OFF);

  // R5: the off phase only leads into a probe window
  p_off_to_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_OFF |=> state != ST_ARMED);

  // R5: the slot phase stays inside one period
  p_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PW'(PERIOD_US));
endmodule

// File: rtl/ocp_irq_latch.sv
// Sticky fault-interrupt bit; a set wins over a read in the same cycle.
module ocp_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_evt,
  input  logic status_rd,
  output logic sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= 1'b0;
    end else if (fault_evt) begin
      sticky <= 1'b1;
    end else if (status_rd) begin
      sticky <= 1'b0;
    end
  end

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> sticky);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sticky && !status_rd |=> sticky);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !fault_evt |=> !sticky);
endmodule

// File: rtl/short_fault_supervisor.sv
module short_fault_supervisor
  import ocp_sup_pkg::*;
#(
  parameter int PERSIST_US = 440,
  parameter int PERIOD_US  = 26000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic ovc_flag,
  input  logic status_rd,
  output logic drv_en,
  output logic fault_live,
  output logic fault_sticky,
  output logic irq_n
);
  sup_state_e state;
  logic       fault_evt;
  logic       armed;

  assign armed = (state == ST_ARMED);

  ocp_persist #(.PERSIST_US(PERSIST_US)) u_persist (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (us_tick),
    .ovc       (ovc_flag),
    .armed     (armed),
    .fault_evt (fault_evt)
  );

  ocp_retry_sched #(.PERSIST_US(PERSIST_US), .PERIOD_US(PERIOD_US)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (us_tick),
    .ovc       (ovc_flag),
    .fault_evt (fault_evt),
    .state     (state)
  );

  ocp_irq_latch u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (fault_evt),
    .status_rd (status_rd),
    .sticky    (fault_sticky)
  );

  assign drv_en     = (state != ST_OFF);
  assign fault_live = (state != ST_ARMED);
  assign irq_n      = ~fault_sticky;

  // R7: the driver is off only while a fault is live
  p_off_needs_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_live |-> drv_en);

  // R3: a new fault always raises the sticky bit with it
  p_rise_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_live) |-> fault_sticky && !irq_n);

  // R8: a read leaves the live fault bit alone
  p_read_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && fault_live && !drv_en |=> fault_live);
endmodule

// File: tb/test_short_fault_supervisor.sv
module test_short_fault_supervisor;
  localparam int PERSIST = 4;
  localparam int PERIOD  = 20;
  localparam int OFF_LEN = PERIOD - PERSIST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic ovc_flag = 1'b0;
  logic status_rd = 1'b0;
  logic drv_en, fault_live, fault_sticky, irq_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  short_fault_supervisor #(.PERSIST_US(PERSIST), .PERIOD_US(PERIOD)) i_short_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ovc_flag(ovc_flag),
    .status_rd(status_rd), .drv_en(drv_en), .fault_live(fault_live),
    .fault_sticky(fault_sticky), .irq_n(irq_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t);
    us_tick = t;
    @(posedge clk);
    @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      step(1'b0);
    end
  endtask

  task automatic t_reset();
    chk("R1", "drv_en", drv_en, 1'b1);
    chk("R1", "fault_live", fault_live, 1'b0);
    chk("R1", "fault_sticky", fault_sticky, 1'b0);
    chk("R1", "irq_n", irq_n, 1'b1);
  endtask

  task automatic t_no_tick();
    ovc_flag = 1'b1;
    for (int i = 0; i < 50; i++) step(1'b0);
    chk("R4", "fault_live without ticks", fault_live, 1'b0);
    chk("R4", "drv_en without ticks", drv_en, 1'b1);
    ovc_flag = 1'b0;
    step(1'b0);
  endtask

  task automatic t_glitch_then_fault();
    ovc_flag = 1'b1;
    ticks(PERSIST - 1);
    ovc_flag = 1'b0;
    step(1'b0);
    ovc_flag = 1'b1;
    ticks(PERSIST - 1);
    chk("R2", "fault_live after restart", fault_live, 1'b0);
    chk("R2", "drv_en after restart", drv_en, 1'b1);
    step(1'b1);
    chk("R3", "drv_en", drv_en, 1'b0);
    chk("R3", "fault_live", fault_live, 1'b1);
    chk("R3", "fault_sticky", fault_sticky, 1'b1);
    chk("R3", "irq_n", irq_n, 1'b0);
    step(1'b0);
  endtask

  task automatic t_read_and_fail();
    status_rd = 1'b1;
    step(1'b0);
    status_rd = 1'b0;
    chk("R8", "sticky after read", fault_sticky, 1'b0);
    chk("R8", "irq_n after read", irq_n, 1'b1);
    chk("R8", "live kept by read", fault_live, 1'b1);
    chk("R8", "drv_en kept by read", drv_en, 1'b0);
    ticks(OFF_LEN - 1);
    chk("R5", "drv_en before window", drv_en, 1'b0);
    ticks(1);
    chk("R5", "drv_en window start", drv_en, 1'b1);
    ticks(PERSIST - 1);
    chk("R5", "drv_en end of window", drv_en, 1'b1);
    ticks(1);
    chk("R6", "drv_en after failed probe", drv_en, 1'b0);
    chk("R6", "fault_live after failed probe", fault_live, 1'b1);
    chk("R6", "sticky not re-set", fault_sticky, 1'b0);
  endtask

  task automatic t_pulse_fail();
    ovc_flag = 1'b0;
    ticks(OFF_LEN - 1);
    chk("R5", "drv_en second slot off", drv_en, 1'b0);
    ticks(1);
    chk("R5", "second window start", drv_en, 1'b1);
    ticks(1);
    ovc_flag = 1'b1;
    step(1'b0);
    ovc_flag = 1'b0;
    ticks(PERSIST - 2);
    chk("R6", "drv_en in window after pulse", drv_en, 1'b1);
    ticks(1);
    chk("R6", "drv_en after pulse probe", drv_en, 1'b0);
    chk("R6", "fault_live after pulse probe", fault_live, 1'b1);
  endtask

  task automatic t_recover();
    ticks(OFF_LEN);
    chk("R5", "third window start", drv_en, 1'b1);
    ticks(PERSIST);
    chk("R7", "fault_live cleared", fault_live, 1'b0);
    chk("R7", "drv_en stays on", drv_en, 1'b1);
    chk("R8", "sticky unchanged by recovery", fault_sticky, 1'b0);
    ovc_flag = 1'b1;
    ticks(PERSIST - 1);
    chk("R7", "no early refault", fault_live, 1'b0);
    ticks(1);
    chk("R7", "refault registered", fault_live, 1'b1);
    chk("R3", "sticky on refault", fault_sticky, 1'b1);
  endtask

  task automatic t_read_collision();
    ovc_flag = 1'b0;
    status_rd = 1'b1;
    step(1'b0);
    status_rd = 1'b0;
    ticks(OFF_LEN + PERSIST);
    chk("R7", "recovered before collision", fault_live, 1'b0);
    chk("R8", "sticky clear before collision", fault_sticky, 1'b0);
    ovc_flag = 1'b1;
    ticks(PERSIST - 1);
    status_rd = 1'b1;
    step(1'b1);
    status_rd = 1'b0;
    chk("R8", "set wins over read", fault_sticky, 1'b1);
    chk("R8", "irq_n with collision", irq_n, 1'b0);
    status_rd = 1'b1;
    step(1'b0);
    status_rd = 1'b0;
    chk("R8", "later read clears", fault_sticky, 1'b0);
    chk("R8", "live kept after read", fault_live, 1'b1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_tick();
    t_glitch_then_fault();
    t_read_and_fail();
    t_pulse_fail();
    t_recover();
    t_read_collision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule